// File: doc/BRIEF.md
# Strip Channel Quality Grader

The grader receives the calibration results of one silicon strip detector module as a stream of channel beats. Each beat carries two 8-bit ADC values: a laser-response amplitude and a pedestal width. Each channel is classified on its own. A channel with too small a laser response is dead. A channel with too wide a pedestal is noisy. Dead, noisy and bad (dead or noisy) channels are tallied together with the total channel count.

When the beat marked last is accepted, the module is graded. The bad fraction is compared against two per-mille limits by cross-multiplication, so no divider is needed. The grade, the usable flag and the dead and noisy counts appear with a one-cycle done pulse. They stay on the outputs until the next module finishes.

A module may be ended with an empty marker beat that carries no channel. This allows a module of zero channels. The tallies restart on the first beat accepted after a module ends, so the next module may begin in the same cycle as the done pulse.

Top module: `strip_qual_grader`

## Requirements
- R1: A counted channel is dead when its amplitude is below 40. An amplitude of exactly 40 is not dead.
- R2: A counted channel is noisy when its pedestal width is above 6. A width of exactly 6 is not noisy.
- R3: A channel that is both dead and noisy adds one to the dead count and one to the noisy count. It adds only one to the bad total used for grading.
- R4: Grade code 0 (A) is given when bad×1000 < 26×N, where N is the number of channels counted in the module.
- R5: Grade code 1 (B) is given when grade A is not met and bad×1000 < 52×N.
- R6: Grade code 2 (reject) is given otherwise, and `res_usable` is then low. `res_usable` is high for codes 0 and 1.
- R7: A beat with `in_empty` high carries no channel and changes no count. A module whose only beat is an empty last beat has N = 0 and is graded reject with both counts 0.
- R8: `res_done` is high for exactly the one cycle after a beat with `in_last` is accepted. The grade, the usable flag and the counts hold their values until the next done pulse.
- R9: The counts restart at the first beat accepted after a last beat, even when that beat arrives in the cycle of the done pulse. The results of the finished module stay unchanged.
- R10: `in_ready` is high in every cycle out of reset. Cycles with `in_valid` low change no count.
- R11: After reset `res_done` is 0, the grade is 2, `res_usable` is 0 and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat can be accepted |
| in_amp | input | 8 | Laser-response amplitude, ADC counts |
| in_pedw | input | 8 | Pedestal width, ADC counts |
| in_last | input | 1 | Final beat of the module |
| in_empty | input | 1 | Beat carries no channel |
| res_done | output | 1 | One-cycle pulse when results are new |
| res_grade | output | 2 | 0 = A, 1 = B, 2 = reject |
| res_usable | output | 1 | Module is grade A or B |
| res_dead | output | 16 | Dead channels in the finished module |
| res_noisy | output | 16 | Noisy channels in the finished module |

## Verification
Two functions can fall in the same cycle: presenting the finished module's results with the done pulse, and clearing the tallies on the first channel of the next module. The bench provokes this by driving the next module's first beat in the cycle right after the previous last beat, with no idle cycle between them. It then checks two things. The done-cycle outputs must still describe the first module. The second module's counts and grade must contain nothing left over from the first.

// File: rtl/sqg_pkg.sv
package sqg_pkg;
    localparam int AMP_W = 8;

    typedef enum logic [1:0] {
        GRADE_A   = 2'd0,
        GRADE_B   = 2'd1,
        GRADE_REJ = 2'd2
    } grade_e;

    typedef struct packed {
        logic dead;
        logic noisy;
    } chan_flags_t;

    typedef struct packed {
        logic [AMP_W-1:0] amp;
        logic [AMP_W-1:0] pedw;
    } chan_meas_t;

    function automatic logic is_bad(input chan_flags_t f);
        return f.dead | f.noisy;
    endfunction
endpackage

// File: rtl/sqg_flag.sv
module sqg_flag
    import sqg_pkg::*;
#(
    parameter int DEAD_TH  = 40,
    parameter int NOISY_TH = 6
) (
    input  chan_meas_t  meas,
    output chan_flags_t flags
);
    always_comb begin
        flags.dead  = (int'(meas.amp) < DEAD_TH);
        flags.noisy = (int'(meas.pedw) > NOISY_TH);
    end
endmodule

// File: rtl/sqg_tally.sv
module sqg_tally
    import sqg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat,
    input  logic             is_chan,
    input  logic             fin,
    input  chan_flags_t      flags,
    output logic [CNT_W-1:0] sum_chan,
    output logic [CNT_W-1:0] sum_bad,
    output logic [CNT_W-1:0] sum_dead,
    output logic [CNT_W-1:0] sum_noisy
);
    logic             fresh_q;
    logic [CNT_W-1:0] chan_q, bad_q, dead_q, noisy_q;
    logic [CNT_W-1:0] chan_b, bad_b, dead_b, noisy_b;

    always_comb begin
        chan_b  = fresh_q ? '0 : chan_q;
        bad_b   = fresh_q ? '0 : bad_q;
        dead_b  = fresh_q ? '0 : dead_q;
        noisy_b = fresh_q ? '0 : noisy_q;
        sum_chan  = chan_b  + CNT_W'(is_chan);
        sum_bad   = bad_b   + CNT_W'(is_chan & is_bad(flags));
        sum_dead  = dead_b  + CNT_W'(is_chan & flags.dead);
        sum_noisy = noisy_b + CNT_W'(is_chan & flags.noisy);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_q <= 1'b1;
            chan_q  <= '0;
            bad_q   <= '0;
            dead_q  <= '0;
            noisy_q <= '0;
        end else if (beat) begin
            fresh_q <= fin;
            chan_q  <= sum_chan;
            bad_q   <= sum_bad;
            dead_q  <= sum_dead;
            noisy_q <= sum_noisy;
        end
    end

    // R3
    tally_bad_le_sum_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, bad_q} <= {1'b0, dead_q} + {1'b0, noisy_q}));
    // R3
    tally_bad_le_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_q <= chan_q));
    // R10
    tally_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !beat |=> $stable(chan_q) && $stable(bad_q));
endmodule

// File: rtl/sqg_judge.sv
module sqg_judge
    import sqg_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SCALE = 1000,
    parameter int LIM_A = 26,
    parameter int LIM_B = 52
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fin,
    input  logic [CNT_W-1:0] sum_chan,
    input  logic [CNT_W-1:0] sum_bad,
    input  logic [CNT_W-1:0] sum_dead,
    input  logic [CNT_W-1:0] sum_noisy,
    output logic             done,
    output grade_e           grade,
    output logic             usable,
    output logic [CNT_W-1:0] dead,
    output logic [CNT_W-1:0] noisy
);
    localparam int SW = $clog2(SCALE + 1);
    localparam int PW = CNT_W + SW;

    logic [PW-1:0] bad_scaled, lim_a_n, lim_b_n;
    grade_e        grade_d;

    always_comb begin
        bad_scaled = PW'(sum_bad)  * PW'(SCALE);
        lim_a_n    = PW'(sum_chan) * PW'(LIM_A);
        lim_b_n    = PW'(sum_chan) * PW'(LIM_B);
        if (sum_chan == '0)            grade_d = GRADE_REJ;
        else if (bad_scaled < lim_a_n) grade_d = GRADE_A;
        else if (bad_scaled < lim_b_n) grade_d = GRADE_B;
        else                           grade_d = GRADE_REJ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            grade  <= GRADE_REJ;
            usable <= 1'b0;
            dead   <= '0;
            noisy  <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                grade  <= grade_d;
                usable <= (grade_d != GRADE_REJ);
                dead   <= sum_dead;
                noisy  <= sum_noisy;
            end
        end
    end

    // R8
    judge_done_after_fin_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> done);
    // R8
    judge_no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !fin |=> !done);
    // R8
    judge_result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(grade) && $stable(dead) && $stable(noisy));
    // R6
    judge_reject_unusable_chk: assert property (@(posedge clk) disable iff (rst)
        (grade == GRADE_REJ) |-> !usable);
endmodule

// File: rtl/strip_qual_grader.sv
module strip_qual_grader
    import sqg_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DEAD_TH  = 40,
    parameter int NOISY_TH = 6,
    parameter int SCALE    = 1000,
    parameter int LIM_A    = 26,
    parameter int LIM_B    = 52
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_amp,
    input  logic [7:0]       in_pedw,
    input  logic             in_last,
    input  logic             in_empty,
    output logic             res_done,
    output logic [1:0]       res_grade,
    output logic             res_usable,
    output logic [CNT_W-1:0] res_dead,
    output logic [CNT_W-1:0] res_noisy
);
    chan_meas_t       meas;
    chan_flags_t      flags;
    logic             beat, is_chan, fin;
    logic [CNT_W-1:0] s_chan, s_bad, s_dead, s_noisy;
    grade_e           grade;

    assign in_ready = !rst;
    assign beat     = in_valid && in_ready;
    assign is_chan  = beat && !in_empty;
    assign fin      = beat && in_last;
    assign meas     = '{amp: in_amp, pedw: in_pedw};

    sqg_flag #(.DEAD_TH(DEAD_TH), .NOISY_TH(NOISY_TH)) flag_i (
        .meas (meas),
        .flags(flags)
    );

    sqg_tally #(.CNT_W(CNT_W)) tally_i (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat),
        .is_chan  (is_chan),
        .fin      (fin),
        .flags    (flags),
        .sum_chan (s_chan),
        .sum_bad  (s_bad),
        .sum_dead (s_dead),
        .sum_noisy(s_noisy)
    );

    sqg_judge #(.CNT_W(CNT_W), .SCALE(SCALE), .LIM_A(LIM_A), .LIM_B(LIM_B)) judge_i (
        .clk      (clk),
        .rst      (rst),
        .fin      (fin),
        .sum_chan (s_chan),
        .sum_bad  (s_bad),
        .sum_dead (s_dead),
        .sum_noisy(s_noisy),
        .done     (res_done),
        .grade    (grade),
        .usable   (res_usable),
        .dead     (res_dead),
        .noisy    (res_noisy)
    );

    assign res_grade = grade;

    // R10
    top_ready_out_of_reset_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready);
endmodule

// File: tb/strip_qual_grader_tb.sv
module strip_qual_grader_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_last, in_empty;
    logic [7:0]  in_amp, in_pedw;
    logic        in_ready, res_done, res_usable;
    logic [1:0]  res_grade;
    logic [15:0] res_dead, res_noisy;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    strip_qual_grader dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_amp(in_amp), .in_pedw(in_pedw), .in_last(in_last), .in_empty(in_empty),
        .res_done(res_done), .res_grade(res_grade), .res_usable(res_usable),
        .res_dead(res_dead), .res_noisy(res_noisy)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_grade(input int nbad, input int n);
        if (n == 0) return 2;
        if (nbad * 1000 < 26 * n) return 0;
        if (nbad * 1000 < 52 * n) return 1;
        return 2;
    endfunction

    task automatic drive(input int amp, input int ped, input bit last, input bit empty);
        in_valid = 1'b1;
        in_amp   = 8'(amp);
        in_pedw  = 8'(ped);
        in_last  = last;
        in_empty = empty;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_empty = 1'b0;
    endtask

    // Channels: d dead-only (amp 39), ns noisy-only (ped 7), b both,
    // remainder on the boundary values 40 / 6 that must not be flagged.
    task automatic run_module(input string tag, input int n, input int d, input int ns,
                              input int b, input bit gaps, input bit hold_chk);
        int g;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 7 == 3)) begin
                in_valid = 1'b0;
                in_amp   = 8'd0;
                in_pedw  = 8'd255;
                @(negedge clk);
            end
            if (i < d)               drive(39, 0, i == n-1, 1'b0);
            else if (i < d+ns)       drive(200, 7, i == n-1, 1'b0);
            else if (i < d+ns+b)     drive(0, 255, i == n-1, 1'b0);
            else                     drive(40, 6, i == n-1, 1'b0);
        end
        g = exp_grade(d+ns+b, n);
        check({tag, " R8 done"}, int'(res_done), 1);
        check({tag, " R1 dead count"}, int'(res_dead), d+b);
        check({tag, " R2 noisy count"}, int'(res_noisy), ns+b);
        check({tag, " R4 R5 R6 grade"}, int'(res_grade), g);
        check({tag, " R6 usable"}, int'(res_usable), int'(g != 2));
        if (hold_chk) begin
            @(negedge clk);
            check({tag, " R8 single pulse"}, int'(res_done), 0);
            check({tag, " R8 grade held"}, int'(res_grade), g);
            check({tag, " R8 dead held"}, int'(res_dead), d+b);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_empty = 1'b0;
        in_amp = 8'd0; in_pedw = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 done", int'(res_done), 0);
        check("R11 grade", int'(res_grade), 2);
        check("R11 usable", int'(res_usable), 0);
        check("R11 dead", int'(res_dead), 0);
        check("R11 noisy", int'(res_noisy), 0);
        check("R10 ready", int'(in_ready), 1);
    endtask

    task automatic t_zero();
        drive(0, 255, 1'b1, 1'b1);
        check("R7 done", int'(res_done), 1);
        check("R7 grade", int'(res_grade), 2);
        check("R7 usable", int'(res_usable), 0);
        check("R7 dead", int'(res_dead), 0);
        check("R7 noisy", int'(res_noisy), 0);
        @(negedge clk);
    endtask

    task automatic t_empty_tail();
        // 2 channels, one good and one dead, then an empty last beat: N=2, bad=1 -> reject
        drive(100, 1, 1'b0, 1'b0);
        drive(10, 1, 1'b0, 1'b0);
        drive(0, 255, 1'b1, 1'b1);
        check("R7 empty tail dead", int'(res_dead), 1);
        check("R7 empty tail noisy", int'(res_noisy), 0);
        check("R7 empty tail grade", int'(res_grade), 2);
        @(negedge clk);
    endtask

    task automatic t_back_to_back();
        run_module("b2b first", 1000, 30, 20, 10, 1'b0, 1'b0);
        // R9: next module's first beat is accepted in the done cycle
        run_module("b2b second R9", 40, 0, 0, 0, 1'b0, 1'b0);
        check("R9 second clean dead", int'(res_dead), 0);
        @(negedge clk);
        check("R9 pulse ends", int'(res_done), 0);
    endtask

    initial begin
        t_reset();
        run_module("A R3", 1000, 10, 10, 5, 1'b1, 1'b1);
        run_module("B low edge R5", 1000, 26, 0, 0, 1'b0, 1'b1);
        run_module("B high edge R5", 1000, 0, 40, 11, 1'b1, 1'b1);
        run_module("reject edge R6", 1000, 20, 20, 12, 1'b0, 1'b1);
        run_module("single good R4", 1, 0, 0, 0, 1'b0, 1'b1);
        run_module("single both R3", 1, 0, 0, 1, 1'b0, 1'b1);
        run_module("gaps R10", 500, 5, 3, 4, 1'b1, 1'b1);
        t_zero();
        t_empty_tail();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule